// File: doc/BRIEF.md
# Serial Flash DMA Engine

This block copies a block of 32-bit words between a serial NOR flash and system memory with no processor help once it has been launched. Software loads a system-memory start address, a flash start address, a byte count, a per-size burst enable set, a direction and a chip-select, then writes the launch bit. The engine works through the transfer one burst at a time. Each burst is first staged in a small internal buffer and then delivered to the other side.

On the flash side the engine uses a word-granular command port: one request per word, either a read or a program, sent to one of two chip-selects. The pin-level serializer sits behind that port. On the system side it acts as a bus master. It issues one command per burst (single, or incrementing 4, 8 or 16 beats) and then one beat handshake per word. When the last word has been delivered the engine sets a done flag. That flag can be masked onto an interrupt line and cleared by software.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset the engine is idle (`busy_o` low, CTRL reads 0), `irq_o` is low, the raw done flag reads 0, and neither `fl_req` nor `m_req` is asserted.
- R2: Writing CTRL (index 0) with bit 0 set while idle launches a transfer. `busy_o`, which CTRL bit 0 also reads back, is high from the next cycle until the last word has been delivered, and then drops.
- R3: CTRL bit 1 = 1 moves data from flash to memory, with flash reads (`fl_wr` = 0) and bus writes (`m_write` = 1). Bit 1 = 0 moves data from memory to flash, with bus reads and flash programs (`fl_wr` = 1).
- R4: CTRL bit 4 selects the flash chip-select, and `fl_cs` carries it for every flash request of the transfer.
- R5: The LEN register (index 3, bits 10:0) holds the byte count minus one. The transfer moves LEN[10:2]+1 words (1 to 512, up to 2048 bytes). Word i uses flash address FLASH_ADDR+4i (index 2) and memory address MEM_ADDR+4i (index 1), and the destination receives the source words unchanged.
- R6: Each bus command takes the longest burst whose enable bit in the burst register (index 4: bit 0 = 4 beats, bit 1 = 8, bit 2 = 16) is set and that does not exceed the remaining words. `m_burst` reads 0 for single, 1 for 4, 2 for 8 and 3 for 16 beats, and `m_addr` is the memory address of the burst's first word.
- R7: When no enabled burst fits the remaining words, including when no enable bit is set at all, the remaining words go out as single-beat commands.
- R8: Completion sets the raw done flag (bit 1 of index 5). Writing 1 to bit 1 of the clear register (index 8) clears it.
- R9: `irq_o` and bit 1 of the masked status (index 7) equal the raw flag ANDed with mask bit 1 (index 6).
- R10: A CTRL write while busy is ignored completely. The transfer's direction, chip-select and remaining length are unchanged, and no second transfer follows.
- R11: `fl_req` with `fl_addr`, and `m_req` with `m_addr` and `m_burst`, stay asserted and stable until `fl_ack` or `m_gnt` accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Masked done interrupt |
| fl_req | output | 1 | Flash word request |
| fl_wr | output | 1 | 1 = program word, 0 = read word |
| fl_cs | output | 1 | Flash chip-select |
| fl_addr | output | 32 | Flash byte address |
| fl_wdata | output | 32 | Flash program data |
| fl_ack | input | 1 | Flash request accepted (read data valid) |
| fl_rdata | input | 32 | Flash read data |
| m_req | output | 1 | Bus burst command request |
| m_write | output | 1 | 1 = write burst, 0 = read burst |
| m_addr | output | 32 | Burst start byte address |
| m_burst | output | 2 | Burst kind: 0 single, 1 four, 2 eight, 3 sixteen beats |
| m_gnt | input | 1 | Bus command accepted |
| m_dreq | output | 1 | Data beat pending |
| m_wdata | output | 32 | Write beat data |
| m_dack | input | 1 | Beat accepted (read data valid) |
| m_rdata | input | 32 | Read beat data |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses and data and an 11-bit length field. That puts the full 512-word transfer within reach, and with it a run of thirty-two 16-beat bursts. Directed cases cover every burst enable subset that matters: 16-beat only, 8-beat with a single-beat tail, 4-beat with a tail, no enables, and a one-word transfer. Seeded random transfers mix direction, chip-select, length and enables under random handshake stalls on both ports.

// File: rtl/fdma_pkg.sv
// Shared constants and types for the flash DMA engine.
package fdma_pkg;
    localparam int MAX_BURST = 16;

    localparam logic [3:0] REG_CTRL  = 4'd0;
    localparam logic [3:0] REG_MADDR = 4'd1;
    localparam logic [3:0] REG_FADDR = 4'd2;
    localparam logic [3:0] REG_LEN   = 4'd3;
    localparam logic [3:0] REG_BEN   = 4'd4;
    localparam logic [3:0] REG_RAW   = 4'd5;
    localparam logic [3:0] REG_MASK  = 4'd6;
    localparam logic [3:0] REG_STAT  = 4'd7;
    localparam logic [3:0] REG_CLR   = 4'd8;

    localparam int CTRL_GO  = 0;
    localparam int CTRL_DIR = 1;
    localparam int CTRL_CS  = 4;
    localparam int DONE_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PLAN, ST_FLASH, ST_BCMD, ST_BUS, ST_NEXT
    } fdma_state_e;
endpackage

// File: rtl/fdma_burst_pick.sv
// Chooses the longest enabled incrementing burst that fits the remaining words.
// Assumes: en[0]=4, en[1]=8, en[2]=16 beats; falls back to a single beat.
module fdma_burst_pick #(
    parameter int CNT_W  = 10,
    parameter int BEAT_W = 5
) (
    input  logic [CNT_W-1:0]  remain,
    input  logic [2:0]        en,
    output logic [BEAT_W-1:0] beats,
    output logic [1:0]        code
);
    // Priority pick from longest to shortest burst.
    always_comb begin
        beats = BEAT_W'(1);
        code  = 2'd0;
        if (en[2] && remain >= CNT_W'(16)) begin
            beats = BEAT_W'(16);
            code  = 2'd3;
        end else if (en[1] && remain >= CNT_W'(8)) begin
            beats = BEAT_W'(8);
            code  = 2'd2;
        end else if (en[0] && remain >= CNT_W'(4)) begin
            beats = BEAT_W'(4);
            code  = 2'd1;
        end
    end

    // R6/R7: a chosen burst never runs past the remaining words.
    always_comb begin
        if (!$isunknown(remain) && remain != '0)
            a_r6_fits_remaining: assert (CNT_W'(beats) <= remain);
    end
endmodule

// File: rtl/fdma_beat_buf.sv
// Staging store for one burst: written by the source side, read by the sink side.
// Assumes: one write port, asynchronous read; contents need no reset.
module fdma_beat_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW_B = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW_B-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [AW_B-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Capture one staged word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word the sink side is on.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fdma_irq.sv
// Done-event flag with mask and write-one clear.
// Assumes: a set and a clear in the same cycle leave the flag set.
module fdma_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic clr_i,
    input  logic mask_wr_i,
    input  logic mask_d_i,
    output logic raw_o,
    output logic mask_o,
    output logic irq_o
);
    // Raw flag: set on completion, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw_o <= 1'b0;
        else if (done_i) raw_o <= 1'b1;
        else if (clr_i)  raw_o <= 1'b0;
    end

    // Mask bit held for software.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= 1'b0;
        else if (mask_wr_i) mask_o <= mask_d_i;
    end

    assign irq_o = raw_o & mask_o;

    a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> raw_o);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !done_i) |=> !raw_o);
endmodule

// File: rtl/flash_dma_engine.sv
// Flash <-> memory DMA engine. Stages each burst in a buffer, then delivers it.
// Assumes: word-aligned addresses; the flash port moves one word per request;
// the bus port takes one command per burst, then one handshake per beat.
module flash_dma_engine
    import fdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          busy_o,
    output logic          irq_o,
    output logic          fl_req,
    output logic          fl_wr,
    output logic          fl_cs,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic          fl_ack,
    input  logic [DW-1:0] fl_rdata,
    output logic          m_req,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_burst,
    input  logic          m_gnt,
    output logic          m_dreq,
    output logic [DW-1:0] m_wdata,
    input  logic          m_dack,
    input  logic [DW-1:0] m_rdata
);
    localparam int LSB    = $clog2(DW / 8);
    localparam int WCNT_W = LEN_W - LSB + 1;
    localparam int IDX_W  = $clog2(MAX_BURST) + 1;
    localparam int BUF_AW = $clog2(MAX_BURST);

    fdma_state_e       st;
    logic [AW-1:0]     cfg_maddr, cfg_faddr, cur_maddr, cur_faddr;
    logic [LEN_W-1:0]  cfg_len;
    logic [2:0]        cfg_ben;
    logic              cfg_dir, cfg_cs;
    logic [WCNT_W-1:0] remain;
    logic [IDX_W-1:0]  idx, blen, pick_beats;
    logic [1:0]        bcode, pick_code;
    logic              launch, done, last_beat, raw, mask;
    logic              buf_we;
    logic [DW-1:0]     buf_wdata, buf_rdata;
    logic [AW-1:0]     step;

    assign busy_o    = (st != ST_IDLE);
    assign launch    = reg_we && reg_addr == REG_CTRL && reg_wdata[CTRL_GO] && !busy_o;
    assign last_beat = (idx == blen - IDX_W'(1));
    assign done      = (st == ST_NEXT) && (remain == WCNT_W'(blen));
    assign step      = AW'(blen) << LSB;

    // Software-visible configuration; CTRL is frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_maddr <= '0; cfg_faddr <= '0; cfg_len <= '0;
            cfg_ben   <= '0; cfg_dir   <= 1'b0; cfg_cs <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                REG_MADDR: cfg_maddr <= reg_wdata[AW-1:0];
                REG_FADDR: cfg_faddr <= reg_wdata[AW-1:0];
                REG_LEN:   cfg_len   <= reg_wdata[LEN_W-1:0];
                REG_BEN:   cfg_ben   <= reg_wdata[2:0];
                REG_CTRL: if (!busy_o) begin
                    cfg_dir <= reg_wdata[CTRL_DIR];
                    cfg_cs  <= reg_wdata[CTRL_CS];
                end
                default: ;
            endcase
        end
    end

    fdma_burst_pick #(.CNT_W(WCNT_W), .BEAT_W(IDX_W)) u_pick (
        .remain(remain), .en(cfg_ben), .beats(pick_beats), .code(pick_code)
    );

    // Transfer sequencer: plan, fill from source, drain to sink, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; idx <= '0; blen <= '0; bcode <= '0;
            remain <= '0; cur_maddr <= '0; cur_faddr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (launch) begin
                    cur_maddr <= cfg_maddr;
                    cur_faddr <= cfg_faddr;
                    remain    <= WCNT_W'(cfg_len[LEN_W-1:LSB]) + WCNT_W'(1);
                    st        <= ST_PLAN;
                end
                ST_PLAN: begin
                    blen  <= pick_beats;
                    bcode <= pick_code;
                    idx   <= '0;
                    st    <= cfg_dir ? ST_FLASH : ST_BCMD;
                end
                ST_FLASH: if (fl_ack) begin
                    idx <= last_beat ? '0 : idx + IDX_W'(1);
                    if (last_beat) st <= cfg_dir ? ST_BCMD : ST_NEXT;
                end
                ST_BCMD: if (m_gnt) st <= ST_BUS;
                ST_BUS: if (m_dack) begin
                    idx <= last_beat ? '0 : idx + IDX_W'(1);
                    if (last_beat) st <= cfg_dir ? ST_NEXT : ST_FLASH;
                end
                ST_NEXT: begin
                    cur_maddr <= cur_maddr + step;
                    cur_faddr <= cur_faddr + step;
                    remain    <= remain - WCNT_W'(blen);
                    st        <= done ? ST_IDLE : ST_PLAN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Stage words from whichever side is the source.
    assign buf_we    = (st == ST_FLASH && fl_ack && cfg_dir) ||
                       (st == ST_BUS && m_dack && !cfg_dir);
    assign buf_wdata = cfg_dir ? fl_rdata : m_rdata;

    fdma_beat_buf #(.DW(DW), .DEPTH(MAX_BURST)) u_buf (
        .clk(clk), .we(buf_we), .waddr(idx[BUF_AW-1:0]), .wdata(buf_wdata),
        .raddr(idx[BUF_AW-1:0]), .rdata(buf_rdata)
    );

    assign fl_req   = (st == ST_FLASH);
    assign fl_wr    = !cfg_dir;
    assign fl_cs    = cfg_cs;
    assign fl_addr  = cur_faddr + (AW'(idx) << LSB);
    assign fl_wdata = buf_rdata;
    assign m_req    = (st == ST_BCMD);
    assign m_write  = cfg_dir;
    assign m_addr   = cur_maddr;
    assign m_burst  = bcode;
    assign m_dreq   = (st == ST_BUS);
    assign m_wdata  = buf_rdata;

    fdma_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_i(done),
        .clr_i(reg_we && reg_addr == REG_CLR && reg_wdata[DONE_BIT]),
        .mask_wr_i(reg_we && reg_addr == REG_MASK), .mask_d_i(reg_wdata[DONE_BIT]),
        .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
    );

    // Register read-back.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_GO]  = busy_o;
                reg_rdata[CTRL_DIR] = cfg_dir;
                reg_rdata[CTRL_CS]  = cfg_cs;
            end
            REG_MADDR: reg_rdata = 32'(cfg_maddr);
            REG_FADDR: reg_rdata = 32'(cfg_faddr);
            REG_LEN:   reg_rdata = 32'(cfg_len);
            REG_BEN:   reg_rdata = 32'(cfg_ben);
            REG_RAW:   reg_rdata[DONE_BIT] = raw;
            REG_MASK:  reg_rdata[DONE_BIT] = mask;
            REG_STAT:  reg_rdata[DONE_BIT] = irq_o;
            default: ;
        endcase
    end

    a_r11_bus_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_burst)));
    a_r11_flash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));
    a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && reg_we && reg_addr == REG_CTRL) |=> ($stable(cfg_dir) && $stable(cfg_cs)));
    a_r6_burst_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_burst != 2'd0) |-> cfg_ben[m_burst - 2'd1]);
    a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_req && m_dreq));
endmodule

// File: tb/test_flash_dma_engine.sv
module test_flash_dma_engine;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        busy_o, irq_o;
    logic        fl_req, fl_wr, fl_cs, fl_ack = 1'b0;
    logic [31:0] fl_addr, fl_wdata, fl_rdata = '0;
    logic        m_req, m_write, m_gnt = 1'b0, m_dreq, m_dack = 1'b0;
    logic [31:0] m_addr, m_wdata, m_rdata = '0;
    logic [1:0]  m_burst;

    always #10 clk = ~clk;

    flash_dma_engine i_flash_dma_engine (.*);

    int checks = 0, fails = 0, cyc = 0, req_cycles = 0;
    logic [31:0] flash [2][1024];
    logic [31:0] sysmem [2048];
    int exp_remain = 0, bus_ptr = 0;
    logic [31:0] exp_maddr = '0, exp_faddr = '0;
    logic [2:0]  exp_ben = '0;
    logic        exp_dir = 1'b0, exp_cs = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pick(input int rem, input logic [2:0] en);
        if (en[2] && rem >= 16) return 16;
        if (en[1] && rem >= 8)  return 8;
        if (en[0] && rem >= 4)  return 4;
        return 1;
    endfunction

    function automatic int code_beats(input logic [1:0] c);
        return (c == 2'd3) ? 16 : (c == 2'd2) ? 8 : (c == 2'd1) ? 4 : 1;
    endfunction

    // Stubs for flash and bus, plus the burst monitor; all act at the falling edge.
    always @(negedge clk) begin
        fl_ack = 1'b0; m_gnt = 1'b0; m_dack = 1'b0;
        if (fl_req || m_req || m_dreq) req_cycles++;
        if (fl_req && ($urandom % 3 != 0)) begin
            fl_ack = 1'b1;
            chk(fl_cs == exp_cs, "R4 chip-select", fl_cs, exp_cs);
            chk(fl_wr == !exp_dir, "R3 flash op", fl_wr, !exp_dir);
            chk(fl_addr == exp_faddr, "R5 flash address", fl_addr, exp_faddr);
            exp_faddr += 4;
            if (fl_wr) flash[fl_cs][fl_addr[11:2]] = fl_wdata;
            else       fl_rdata = flash[fl_cs][fl_addr[11:2]];
        end
        if (m_req && ($urandom % 2 == 0)) begin
            m_gnt = 1'b1;
            chk(code_beats(m_burst) == pick(exp_remain, exp_ben), "R6 R7 burst size",
                code_beats(m_burst), pick(exp_remain, exp_ben));
            chk(m_addr == exp_maddr, "R6 burst address", m_addr, exp_maddr);
            chk(m_write == exp_dir, "R3 bus op", m_write, exp_dir);
            exp_remain -= code_beats(m_burst);
            exp_maddr  += 32'(4 * code_beats(m_burst));
            bus_ptr = int'(m_addr[12:2]);
        end
        if (m_dreq && ($urandom % 4 != 0)) begin
            m_dack = 1'b1;
            if (m_write) sysmem[bus_ptr] = m_wdata;
            else         m_rdata = sysmem[bus_ptr];
            bus_ptr++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 20000) begin @(negedge clk); n++; end
        chk(!busy_o, "R2 busy drops", busy_o, 0);
    endtask

    task automatic launch(input bit dir, input bit cs, input int mw, input int fw,
                          input int len, input logic [2:0] ben);
        wr(4'd1, 32'(mw * 4)); wr(4'd2, 32'(fw * 4));
        wr(4'd3, 32'(len)); wr(4'd4, 32'(ben));
        exp_dir = dir; exp_cs = cs; exp_ben = ben;
        exp_maddr = 32'(mw * 4); exp_faddr = 32'(fw * 4);
        exp_remain = len / 4 + 1;
        wr(4'd0, {27'd0, cs, 2'b00, dir, 1'b1});
        chk(busy_o, "R2 busy after launch", busy_o, 1);
    endtask

    task automatic finish_xfer(input bit dir, input bit cs, input int mw, input int fw, input int len);
        logic [31:0] d;
        wait_idle();
        chk(exp_remain == 0, "R5 R6 word count covered", exp_remain, 0);
        for (int i = 0; i <= len / 4; i++)
            chk(sysmem[mw + i] == flash[cs][fw + i], dir ? "R3 R5 read data" : "R3 R5 write data",
                dir ? sysmem[mw + i] : flash[cs][fw + i], dir ? flash[cs][fw + i] : sysmem[mw + i]);
        rd(4'd5, d);
        chk(d[1] == 1'b1, "R8 raw done set", d[1], 1);
        wr(4'd8, 32'h2);
        rd(4'd5, d);
        chk(d[1] == 1'b0, "R8 raw done cleared", d[1], 0);
    endtask

    task automatic xfer(input bit dir, input bit cs, input int mw, input int fw,
                        input int len, input logic [2:0] ben);
        launch(dir, cs, mw, fw, len, ben);
        finish_xfer(dir, cs, mw, fw, len);
    endtask

    initial begin
        logic [31:0] d;
        int snap;
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 2; c++) for (int i = 0; i < 1024; i++) flash[c][i] = $urandom;
        for (int i = 0; i < 2048; i++) sysmem[i] = $urandom;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'd0, d); chk(d == 32'd0, "R1 CTRL after reset", d, 0);
        rd(4'd5, d); chk(d == 32'd0, "R1 raw after reset", d, 0);
        chk(!busy_o && !irq_o, "R1 busy/irq after reset", {busy_o, irq_o}, 0);
        chk(!fl_req && !m_req, "R1 no requests after reset", {fl_req, m_req}, 0);

        xfer(1, 0, 0, 0, 2047, 3'b111);     // R5 full 512 words, all 16-beat bursts
        xfer(0, 1, 600, 100, 27, 3'b001);   // R7 four-beat plus tail
        xfer(1, 1, 900, 300, 0, 3'b111);    // R7 one word
        xfer(0, 0, 1200, 700, 79, 3'b000);  // R7 no enables
        xfer(1, 0, 1500, 800, 83, 3'b010);  // R6 eight-beat plus tail
        for (int k = 0; k < 10; k++) begin
            int l = $urandom % 2048;
            xfer(1'($urandom), 1'($urandom), $urandom % 1536, $urandom % 512, l, 3'($urandom));
        end

        // R10: CTRL write during busy is ignored
        launch(1, 0, 100, 50, 255, 3'b011);
        repeat (5) @(negedge clk);
        wr(4'd0, 32'h13);
        finish_xfer(1, 0, 100, 50, 255);
        rd(4'd0, d);
        chk(d[1] == 1'b1 && d[4] == 1'b0, "R10 CTRL unchanged", d, 32'h2);
        snap = req_cycles;
        repeat (40) @(negedge clk);
        chk(!busy_o && req_cycles == snap, "R10 no second transfer", req_cycles - snap, 0);

        // R9 mask behaviour
        xfer(0, 1, 40, 40, 15, 3'b001);
        wr(4'd6, 32'h0);
        xfer(1, 1, 60, 60, 15, 3'b001);
        launch(1, 0, 70, 70, 7, 3'b001);
        wait_idle();
        chk(!irq_o, "R9 irq masked", irq_o, 0);
        rd(4'd7, d); chk(d[1] == 1'b0, "R9 status masked", d[1], 0);
        wr(4'd6, 32'h2);
        chk(irq_o, "R9 irq unmasked", irq_o, 1);
        rd(4'd7, d); chk(d[1] == 1'b1, "R9 status unmasked", d[1], 1);
        wr(4'd8, 32'h2);
        chk(!irq_o, "R8 R9 irq after clear", irq_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule